// File: doc/BRIEF.md
# Carry-Increment Adder

A purely combinational adder of configurable width that adds two operands and a carry-in and returns the sum together with a carry-out. The operand bits are split into consecutive groups, counted from the least significant bit, whose sizes grow along the word. A single bitwise stage forms the generate and propagate terms for every bit. Each group then builds its own carries on the assumption that nothing enters it from below, along with the running propagate term for each bit position.

A chain across the groups forms the real carry into each group. An increment stage inside each group merges that carry with the group's running propagate terms, and one XOR stage at the end produces every sum bit. The block has no duplicated per-group adders and no result multiplexers. Group geometry is set by two parameters: the size of the first group and the growth step between groups. The highest group takes whatever bits are left over. A style parameter chooses how each group forms its internal carries, either as a serial chain or as a flat lookahead.

Top module: `cia_adder`

## Requirements
- R1: For every pair of operands and every carry-in, {cout_o, sum_o} equals a_i + b_i + cin_i taken over WIDTH+1 bits.
- R2: With a_i all ones, b_i zero and cin_i = 1, sum_o is zero and cout_o is 1: the carry crosses every group.
- R3: With a_i and b_i both all ones, cin_i = 0 gives sum_o all ones except bit 0, which is 0; cin_i = 1 gives sum_o all ones. Both cases give cout_o = 1.
- R4: With both operands zero, sum_o equals cin_i in bit 0 and zero elsewhere, and cout_o is 0.
- R5: The groups occupy bits from bit 0 upward with sizes FIRST_GRP + g*GRP_STEP for group index g. The last group holds the remaining bits. The carry leaving each group equals the carry of adding that group's operand slices and its incoming carry. A carry generated in a group's top bit appears in the next group's lowest sum bit.
- R6: When every bit only propagates (a_i = ~b_i), sum_o is all ones and cout_o is 0 for cin_i = 0. For cin_i = 1, sum_o is zero and cout_o is 1.
- R7: The serial style (PFX_STYLE = 0) and the lookahead style (PFX_STYLE = 1) give identical sum_o and cout_o for the same inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Sum bits |
| cout_o | output | 1 | Carry out of the top bit |

## Verification
Every result is combinational, so sum_o and cout_o are due in the same cycle in which the operands change, with no register on the path. The bench drives inputs one nanosecond after a rising edge and samples one nanosecond later, well before the next edge. Each check therefore sees settled values from that one stimulus. Three instances run side by side: the default geometry, the lookahead style, and a narrow adder with fixed-size groups. Their results are compared with a sum computed in the bench.

// File: rtl/cia_pkg.sv
package cia_pkg;

   localparam int PFX_SERIAL   = 0;
   localparam int PFX_PARALLEL = 1;

   // number of groups needed to cover width bits
   function automatic int grp_count(input int width, input int first, input int step);
      int lo;
      int n;
      lo = 0;
      n  = 0;
      while (lo < width) begin
         lo = lo + first + n * step;
         n  = n + 1;
      end
      return n;
   endfunction

   // lowest bit index of group g
   function automatic int grp_lo(input int g, input int first, input int step);
      int lo;
      lo = 0;
      for (int n = 0; n < g; n++) lo = lo + first + n * step;
      return lo;
   endfunction

   // bit count of group g; last group takes the remainder
   function automatic int grp_size(input int g, input int width, input int first, input int step);
      int ng;
      ng = grp_count(width, first, step);
      if (g == ng - 1) return width - grp_lo(g, first, step);
      return first + g * step;
   endfunction

endpackage

// File: rtl/cia_pg_stage.sv
module cia_pg_stage #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   output logic [WIDTH-1:0] gen_o,
   output logic [WIDTH-1:0] prop_o
);
   if (WIDTH < 1) begin : g_bad_width
      $error("cia_pg_stage: WIDTH must be at least 1");
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign gen_o[i]  = a_i[i] & b_i[i];
      assign prop_o[i] = a_i[i] ^ b_i[i];
   end
endmodule

// File: rtl/cia_group.sv
module cia_group #(
   parameter int SZ        = 4,
   parameter int PFX_STYLE = cia_pkg::PFX_SERIAL
) (
   input  logic [SZ-1:0] gen_i,
   input  logic [SZ-1:0] prop_i,
   input  logic          gcin_i,
   output logic [SZ-1:0] cbit_o,
   output logic          grp_gen_o,
   output logic          grp_prop_o
);
   if (SZ < 1) begin : g_bad_sz
      $error("cia_group: SZ must be at least 1");
   end
   if (PFX_STYLE != cia_pkg::PFX_SERIAL && PFX_STYLE != cia_pkg::PFX_PARALLEL) begin : g_bad_style
      $error("cia_group: unknown PFX_STYLE");
   end

   logic [SZ-1:0] loc_c;   // carry out of bit i, group carry-in assumed zero
   logic [SZ-1:0] loc_p;   // propagate from group base up to bit i

   if (PFX_STYLE == cia_pkg::PFX_SERIAL) begin : g_serial
      assign loc_c[0] = gen_i[0];
      assign loc_p[0] = prop_i[0];
      for (genvar i = 1; i < SZ; i++) begin : g_chain
         assign loc_c[i] = gen_i[i] | (prop_i[i] & loc_c[i-1]);
         assign loc_p[i] = prop_i[i] & loc_p[i-1];
      end
   end else begin : g_parallel
      always_comb begin
         for (int i = 0; i < SZ; i++) begin
            logic acc_c;
            logic acc_p;
            acc_c = 1'b0;
            acc_p = 1'b1;
            for (int j = 0; j <= i; j++) begin
               logic term;
               term = gen_i[j];
               for (int k = j + 1; k <= i; k++) term = term & prop_i[k];
               acc_c = acc_c | term;
               acc_p = acc_p & prop_i[j];
            end
            loc_c[i] = acc_c;
            loc_p[i] = acc_p;
         end
      end
   end

   // increment stage: fold the real group carry into every local carry
   for (genvar i = 0; i < SZ; i++) begin : g_inc
      assign cbit_o[i] = loc_c[i] | (loc_p[i] & gcin_i);
   end

   assign grp_gen_o  = loc_c[SZ-1];
   assign grp_prop_o = loc_p[SZ-1];

   // R1: a full propagate prefix never coexists with a local generate
   always_comb begin
      for (int i = 0; i < SZ; i++) begin
         p_local_excl_r1: assert (!(loc_c[i] && loc_p[i]))
            else $error("local carry and propagate both set at bit %0d", i);
      end
   end

   // R6: a fully propagating group hands its incoming carry straight on
   always_comb begin
      if (grp_prop_o) begin
         p_prop_pass_r6: assert (cbit_o[SZ-1] == gcin_i)
            else $error("propagating group altered its carry");
      end
   end
endmodule

// File: rtl/cia_sum_stage.sv
module cia_sum_stage #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] prop_i,
   input  logic [WIDTH-1:0] cin_bits_i,
   output logic [WIDTH-1:0] sum_o
);
   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign sum_o[i] = prop_i[i] ^ cin_bits_i[i];
   end
endmodule

// File: rtl/cia_adder.sv
module cia_adder #(
   parameter int WIDTH     = 32,
   parameter int FIRST_GRP = 1,
   parameter int GRP_STEP  = 1,
   parameter int PFX_STYLE = cia_pkg::PFX_SERIAL
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             cin_i,
   output logic [WIDTH-1:0] sum_o,
   output logic             cout_o
);
   if (WIDTH < 1) begin : g_bad_width
      $error("cia_adder: WIDTH must be at least 1");
   end
   if (FIRST_GRP < 1) begin : g_bad_first
      $error("cia_adder: FIRST_GRP must be at least 1");
   end
   if (GRP_STEP < 0) begin : g_bad_step
      $error("cia_adder: GRP_STEP must not be negative");
   end

   localparam int NGRP = cia_pkg::grp_count(WIDTH, FIRST_GRP, GRP_STEP);

   logic [WIDTH-1:0] gen_b, prop_b, cbit, cin_bits;
   logic [NGRP-1:0]  grp_g, grp_p;
   logic [NGRP:0]    gc;

   cia_pg_stage #(.WIDTH(WIDTH)) u_pg (
      .a_i    (a_i),
      .b_i    (b_i),
      .gen_o  (gen_b),
      .prop_o (prop_b)
   );

   assign gc[0] = cin_i;

   for (genvar g = 0; g < NGRP; g++) begin : g_grp
      localparam int LO = cia_pkg::grp_lo(g, FIRST_GRP, GRP_STEP);
      localparam int SZ = cia_pkg::grp_size(g, WIDTH, FIRST_GRP, GRP_STEP);

      cia_group #(.SZ(SZ), .PFX_STYLE(PFX_STYLE)) u_grp (
         .gen_i      (gen_b[LO +: SZ]),
         .prop_i     (prop_b[LO +: SZ]),
         .gcin_i     (gc[g]),
         .cbit_o     (cbit[LO +: SZ]),
         .grp_gen_o  (grp_g[g]),
         .grp_prop_o (grp_p[g])
      );

      // group carry chain: G | P & carry
      assign gc[g+1] = grp_g[g] | (grp_p[g] & gc[g]);

      assign cin_bits[LO] = gc[g];
      if (SZ > 1) begin : g_inner
         assign cin_bits[LO+1 +: SZ-1] = cbit[LO +: SZ-1];
      end

      // R5: carry leaving the group matches slice arithmetic and the increment stage
      always_comb begin
         logic [SZ:0] slice_sum;
         slice_sum = {1'b0, a_i[LO +: SZ]} + {1'b0, b_i[LO +: SZ]} + {{SZ{1'b0}}, gc[g]};
         p_group_carry_r5: assert (slice_sum[SZ] == gc[g+1])
            else $error("group %0d carry mismatch", g);
         p_inc_chain_r5: assert (cbit[LO+SZ-1] == gc[g+1])
            else $error("group %0d increment and chain disagree", g);
      end
   end

   cia_sum_stage #(.WIDTH(WIDTH)) u_sum (
      .prop_i     (prop_b),
      .cin_bits_i (cin_bits),
      .sum_o      (sum_o)
   );

   assign cout_o = gc[NGRP];

   // R1: complete result equals the arithmetic sum
   always_comb begin
      logic [WIDTH:0] ref_sum;
      ref_sum = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};
      p_sum_matches_r1: assert ({cout_o, sum_o} == ref_sum)
         else $error("sum mismatch");
   end
endmodule

// File: tb/tb_cia_adder.sv
module tb_cia_adder;
   localparam int W  = 32;
   localparam int WF = 13;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;   // 250 MHz

   logic [W-1:0]  a, b;
   logic          cin;
   logic [W-1:0]  sum_s, sum_p;
   logic          cout_s, cout_p;
   logic [WF-1:0] sum_f;
   logic          cout_f;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   cia_adder #(.WIDTH(W), .FIRST_GRP(1), .GRP_STEP(1), .PFX_STYLE(0)) dut (
      .a_i(a), .b_i(b), .cin_i(cin), .sum_o(sum_s), .cout_o(cout_s));

   cia_adder #(.WIDTH(W), .FIRST_GRP(1), .GRP_STEP(1), .PFX_STYLE(1)) dut_par (
      .a_i(a), .b_i(b), .cin_i(cin), .sum_o(sum_p), .cout_o(cout_p));

   cia_adder #(.WIDTH(WF), .FIRST_GRP(3), .GRP_STEP(0), .PFX_STYLE(0)) dut_fix (
      .a_i(a[WF-1:0]), .b_i(b[WF-1:0]), .cin_i(cin), .sum_o(sum_f), .cout_o(cout_f));

   task automatic check(input string req, input logic [W:0] act, input logic [W:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // drive one nanosecond after an edge, sample one nanosecond later
   task automatic drive(input logic [W-1:0] av, input logic [W-1:0] bv, input logic c);
      @(posedge clk);
      #1;
      a = av; b = bv; cin = c;
      #1;
   endtask

   function automatic logic [W:0] ref_w(input logic [W-1:0] av, input logic [W-1:0] bv, input logic c);
      return {1'b0, av} + {1'b0, bv} + {{W{1'b0}}, c};
   endfunction

   function automatic logic [W:0] ref_f(input logic [W-1:0] av, input logic [W-1:0] bv, input logic c);
      logic [WF:0] s;
      s = {1'b0, av[WF-1:0]} + {1'b0, bv[WF-1:0]} + {{WF{1'b0}}, c};
      return {{(W-WF){1'b0}}, s};
   endfunction

   task automatic t_reset;
      a = '0; b = '0; cin = 1'b0;
      #1;
      check("R4 reset-state zero", {cout_s, sum_s}, '0);
   endtask

   task automatic t_zero_ops;
      for (int c = 0; c < 2; c++) begin
         drive('0, '0, c[0]);
         check("R4 zero operands", {cout_s, sum_s}, {{W{1'b0}}, c[0]});
         check("R4 zero operands fixed", {{(W-WF){1'b0}}, cout_f, sum_f}, {{W{1'b0}}, c[0]});
      end
   endtask

   task automatic t_full_ripple;
      drive('1, '0, 1'b1);
      check("R2 carry through all groups", {cout_s, sum_s}, {1'b1, {W{1'b0}}});
      check("R2 lookahead style", {cout_p, sum_p}, {1'b1, {W{1'b0}}});
      check("R2 fixed groups", {{(W-WF){1'b0}}, cout_f, sum_f}, ref_f('1, '0, 1'b1));
   endtask

   task automatic t_all_ones;
      drive('1, '1, 1'b0);
      check("R3 all ones cin0", {cout_s, sum_s}, {1'b1, {(W-1){1'b1}}, 1'b0});
      drive('1, '1, 1'b1);
      check("R3 all ones cin1", {cout_s, sum_s}, {1'b1, {W{1'b1}}});
      check("R3 all ones cin1 lookahead", {cout_p, sum_p}, {1'b1, {W{1'b1}}});
   endtask

   task automatic t_propagate_only;
      drive(32'h5555_5555, 32'hAAAA_AAAA, 1'b0);
      check("R6 propagate cin0", {cout_s, sum_s}, {1'b0, {W{1'b1}}});
      drive(32'h5555_5555, 32'hAAAA_AAAA, 1'b1);
      check("R6 propagate cin1", {cout_s, sum_s}, {1'b1, {W{1'b0}}});
      check("R6 propagate cin1 fixed", {{(W-WF){1'b0}}, cout_f, sum_f}, {{(W-WF){1'b0}}, 1'b1, {WF{1'b0}}});
   endtask

   task automatic t_group_edges;
      // default geometry boundaries (sizes 1,2,3,...): 1,3,6,10,15,21,28
      int edges [7] = '{1, 3, 6, 10, 15, 21, 28};
      foreach (edges[k]) begin
         logic [W-1:0] v;
         v = 32'd1 << (edges[k] - 1);
         drive(v, v, 1'b0);
         check($sformatf("R5 boundary %0d", edges[k]), {cout_s, sum_s}, ref_w(v, v, 1'b0));
      end
      // fixed three-bit groups: boundaries 3,6,9,12
      for (int e = 3; e < WF; e += 3) begin
         logic [W-1:0] v;
         v = 32'd1 << (e - 1);
         drive(v, v, 1'b0);
         check($sformatf("R5 fixed boundary %0d", e), {{(W-WF){1'b0}}, cout_f, sum_f}, ref_f(v, v, 1'b0));
      end
      drive({W{1'b1}} >> (W - WF), 32'd1, 1'b0);
      check("R5 fixed carry out", {{(W-WF){1'b0}}, cout_f, sum_f}, {{(W-WF-1){1'b0}}, 1'b1, {WF{1'b0}}});
   endtask

   task automatic t_random;
      for (int n = 0; n < 300; n++) begin
         logic [W-1:0] av, bv;
         logic c;
         av = $urandom;
         bv = $urandom;
         c  = n[0];
         drive(av, bv, c);
         check("R1 random sum", {cout_s, sum_s}, ref_w(av, bv, c));
         check("R7 styles agree", {cout_p, sum_p}, {cout_s, sum_s});
         check("R5 fixed random", {{(W-WF){1'b0}}, cout_f, sum_f}, ref_f(av, bv, c));
      end
   endtask

   initial begin
      t_reset();
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      t_zero_ops();
      t_full_ripple();
      t_all_ones();
      t_propagate_only();
      t_group_edges();
      t_random();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule